// File: doc/BRIEF.md
# Dual-Mode Serial I/O Register

This block holds a 4-bit register that sits between a small processor's accumulator and three serial pins. A mode input picks its job. In shift mode it moves one bit per instruction cycle: the serial input enters at the bottom and the top bit drives the serial output. In counter mode it counts falling edges seen on the serial input.

The processor reads and writes the register only by swapping it with the accumulator. The register's current contents are always visible on `sio_o`. On an instruction cycle that carries an exchange, the accumulator value is loaded into the register. The processor therefore gets the old contents and leaves the new value in a single cycle.

An exchange also arms the serial clock output. While armed and in shift mode, the clock output toggles once per instruction cycle. Software that exchanges exactly every fourth cycle gets an unbroken bit stream.

Top module: `sio_dual_reg`

## Requirements
- R1: While rst_ni is low and after its release, the register reads 0, ser_o and sclk_o are 0, the clock latch is clear and the edge history is 0. After reset, ser_i held low produces no count.
- R2: sio_o always shows the register's current contents. On a clock edge where cyc_stb_i and xchg_i are both 1, the register takes acc_i.
- R3: An exchange wins over a shift or a count on the same edge. The next shift or count acts on the newly loaded value.
- R4: With cnt_mode_i = 0 (shift), each edge with cyc_stb_i = 1 and no exchange sets the register to {reg[2:0], ser_i}. ser_o equals reg[3] in this mode.
- R5: In shift mode the register holds its value on edges where cyc_stb_i = 0.
- R6: With cnt_mode_i = 1 (counter), ser_i is sampled every clock edge. An edge where the previous sample was 1 and the current one is 0 adds 1 to the register, unless an exchange takes that edge. The count wraps from 15 to 0.
- R7: In counter mode ser_o is 0, and the register does not change on rising edges or a steady level of ser_i.
- R8: sclk_o toggles on every edge with cyc_stb_i = 1 while the mode is shift and the clock latch is set. Otherwise it is 0.
- R9: An exchange sets the clock latch. A change of cnt_mode_i clears it, unless an exchange occurs on the same edge.
- R10: In shift mode, exchanging on every fourth cycle strobe puts each loaded value's bits on ser_o, MSB first, with no gap between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_stb_i | input | 1 | One-clock instruction-cycle strobe |
| cnt_mode_i | input | 1 | 0 = shift register, 1 = event counter |
| xchg_i | input | 1 | Exchange request, taken with cyc_stb_i |
| acc_i | input | 4 | Accumulator value to load |
| sio_o | output | 4 | Current register contents (old value on exchange) |
| ser_i | input | 1 | Serial data / count input |
| ser_o | output | 1 | Serial data output |
| sclk_o | output | 1 | Serial clock output |

## Verification
The bench targets the edge where an exchange meets a pending shift or count. A design that lets the shift win would show one bit of the accumulator value already shifted out. It also checks the count at 15: a design that saturates or carries into a fifth bit would fail the wrap check. Directly after reset, ser_i is held low to catch edge history that starts at 1, which would log a false count. The bench then changes mode while the clock is armed; a latch that stays armed would keep toggling sclk_o in the wrong mode or after the switch back.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned SIO_W = 4;
  typedef enum logic {MODE_SHIFT = 1'b0, MODE_COUNT = 1'b1} sio_mode_e;
endpackage

// File: rtl/sio_fall_det.sv
module sio_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ser_i;

  assign fall_o = prev_q & ~ser_i;

  // R1: history cleared, so a low input right after reset is no edge
  p_hist_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_i |=> !fall_o);
endmodule

// File: rtl/sio_sclk_ctl.sv
module sio_sclk_ctl
  import sio_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stb_i,
  input  logic      xchg_i,
  input  sio_mode_e mode_i,
  output logic      sclk_o
);
  sio_mode_e mode_q;
  logic en_q, tog_q, gate;

  assign gate = en_q & (mode_i == MODE_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q <= MODE_SHIFT;
      en_q   <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (stb_i && xchg_i)     en_q <= 1'b1;
      else if (mode_i != mode_q) en_q <= 1'b0;
      if (!gate)      tog_q <= 1'b0;
      else if (stb_i) tog_q <= ~tog_q;
    end

  assign sclk_o = tog_q & gate;

  p_latch_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && xchg_i |=> en_q);
  p_latch_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q) && !(stb_i && xchg_i) |=> !en_q);
  p_sclk_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate && stb_i |=> tog_q != $past(tog_q));
  p_sclk_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate && !stb_i |=> tog_q == $past(tog_q));
endmodule

// File: rtl/sio_dual_reg.sv
module sio_dual_reg
  import sio_pkg::*;
#(
  parameter int unsigned W = SIO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_stb_i,
  input  logic         cnt_mode_i,
  input  logic         xchg_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] sio_o,
  input  logic         ser_i,
  output logic         ser_o,
  output logic         sclk_o
);
  localparam logic [W-1:0] ONE = W'(1);

  sio_mode_e    mode;
  logic         fall, do_xchg;
  logic [W-1:0] q;

  assign mode    = sio_mode_e'(cnt_mode_i);
  assign do_xchg = cyc_stb_i & xchg_i;

  sio_fall_det u_fall (
    .clk_i (clk_i), .rst_ni (rst_ni), .ser_i (ser_i), .fall_o (fall)
  );

  sio_sclk_ctl u_sclk (
    .clk_i (clk_i), .rst_ni (rst_ni), .stb_i (cyc_stb_i),
    .xchg_i (xchg_i), .mode_i (mode), .sclk_o (sclk_o)
  );

  // exchange has priority over shift and count
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            q <= '0;
    else if (do_xchg)                       q <= acc_i;
    else if (mode == MODE_SHIFT && cyc_stb_i) q <= {q[W-2:0], ser_i};
    else if (mode == MODE_COUNT && fall)    q <= q + ONE;

  assign sio_o = q;
  assign ser_o = (mode == MODE_SHIFT) ? q[W-1] : 1'b0;

  p_xchg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_xchg |=> sio_o == $past(acc_i));
  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_mode_i && cyc_stb_i && !xchg_i |=> sio_o == {$past(sio_o[W-2:0]), $past(ser_i)});
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_mode_i && !cyc_stb_i |=> $stable(sio_o));
  p_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_mode_i && fall && !do_xchg |=> sio_o == $past(sio_o) + ONE);
  p_no_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_mode_i && !fall && !do_xchg |=> $stable(sio_o));
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> sio_o == '0 && !sclk_o);
endmodule

// File: tb/sim_sio_dual_reg.sv
module sim_sio_dual_reg;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic stb = 0, mode = 0, xchg = 0, ser = 0;
  logic [3:0] acc = 0, sio;
  logic ser_o, sclk_o;
  int n_chk = 0, n_fail = 0;

  // bench reference state
  logic [3:0] m_q = 0;
  logic m_prev = 0, m_en = 0, m_tog = 0, m_mode_q = 0;

  always #5 clk = ~clk;

  sio_dual_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_stb_i(stb), .cnt_mode_i(mode),
    .xchg_i(xchg), .acc_i(acc), .sio_o(sio), .ser_i(ser),
    .ser_o(ser_o), .sclk_o(sclk_o)
  );

  function automatic logic exp_ser(logic [3:0] q, logic md);
    return md ? 1'b0 : q[3];
  endfunction

  function automatic logic exp_sclk(logic tg, logic en, logic md);
    return tg & en & ~md;
  endfunction

  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk(tag, "sio_o", sio, m_q);
    chk(tag, "ser_o", {3'b0, ser_o}, {3'b0, exp_ser(m_q, mode)});
    chk(tag, "sclk_o", {3'b0, sclk_o}, {3'b0, exp_sclk(m_tog, m_en, mode)});
  endtask

  // one clock: drive at negedge, check, then advance the model at posedge
  task automatic step(string tag, logic s, logic md, logic x, logic [3:0] a, logic si);
    logic gate, fall;
    stb = s; mode = md; xchg = x; acc = a; ser = si;
    #1 chk_outs(tag);
    @(posedge clk);
    gate = m_en & ~md;
    fall = m_prev & ~si;
    if (s && x)         m_q = a;
    else if (!md && s)  m_q = {m_q[2:0], si};
    else if (md && fall) m_q = m_q + 4'd1;
    m_prev = si;
    if (s && x)              m_en = 1'b1;
    else if (md != m_mode_q) m_en = 1'b0;
    m_mode_q = md;
    if (!gate)  m_tog = 1'b0;
    else if (s) m_tog = ~m_tog;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] words [4];
    void'($urandom(32'd7321));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_outs("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    repeat (4) step("R1", 1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
    chk("R1", "no count from cleared history", sio, 4'h0);

    // R2, R3: exchange in shift mode, exchange wins over shift
    step("R2", 1'b1, 1'b0, 1'b1, 4'hA, 1'b1);
    chk("R3", "exchange beats shift", sio, 4'hA);
    step("R4", 1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    chk("R4", "shift of loaded value", sio, 4'h5);
    // R5: hold without strobe
    step("R5", 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    chk("R5", "hold without strobe", sio, 4'h5);

    // R10: exchange every fourth strobe, stream MSB first
    words[0] = 4'hC; words[1] = 4'h3; words[2] = 4'h9; words[3] = 4'h6;
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++) begin
        step("R10", 1'b1, 1'b0, b == 0, words[w], 1'b0);
        chk("R10", "stream bit", {3'b0, ser_o}, {3'b0, words[w][3-b]});
      end

    // R8: sclk toggles with latch set, clears on mode change (R9)
    step("R8", 1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    step("R9", 1'b1, 1'b1, 1'b0, 4'h0, 1'b0);
    chk("R9", "sclk low in counter mode", {3'b0, sclk_o}, 4'h0);
    step("R9", 1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    step("R9", 1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    chk("R9", "latch cleared by mode change", {3'b0, sclk_o}, 4'h0);

    // R6, R7: counter wrap, rising edges ignored
    step("R3", 1'b1, 1'b1, 1'b1, 4'hE, 1'b1);
    step("R7", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1);
    chk("R7", "level high no count", sio, 4'hE);
    step("R6", 1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
    step("R7", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1);
    chk("R7", "rising edge no count", sio, 4'hF);
    step("R6", 1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
    chk("R6", "wrap 15 to 0", sio, 4'h0);
    step("R7", 1'b0, 1'b1, 1'b0, 4'h0, 1'b1);
    step("R3", 1'b1, 1'b1, 1'b1, 4'h7, 1'b0);
    chk("R3", "exchange beats count", sio, 4'h7);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) mode = ~mode;
      step("R2/R4/R6/R8", 1'($urandom_range(0, 1)), mode,
           $urandom_range(0, 3) == 0, 4'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule